// File: doc/BRIEF.md
# Instruction Word Decoder with Legality Checking

This block turns one 32-bit fixed-length instruction word into the controls an execute stage needs. A 6-bit opcode in the top bits picks the operation and the layout of the rest of the word. The decoder splits out the three register fields, the shift amount and the 16-bit immediate. It extends the immediate according to the operation, and it drives a one-hot vector with one line per defined operation. The whole path is combinational: outputs follow the inputs in the same cycle.

Alongside the decode, the block rejects malformed words. It flags an opcode with no definition. It flags a shift amount on an operation that does not shift. It flags a register field that the operation ignores but which does not hold the reserved "no register" code. It flags an operand field that the operation reads but which holds that reserved code. It also flags an interrupt code wider than eight bits. A rejected word raises only the illegal flag, and every other output stays at zero so that nothing downstream acts on it.

Top module: `instr_decoder`

## Requirements
- R1: With `valid_i` high and the word legal, `fmt_o` is 1 (immediate layout) for opcodes 0x03 to 0x13, 0x22, 0x25 and 0x26, and 0 (register layout) for every other defined opcode 0x00 to 0x26; the value 2 is never driven.
- R2: For a legal word, `fld_a_o` is bits 25..21 and `fld_b_o` is bits 20..16. `fld_c_o` is bits 15..11 and `shamt_o` is bits 10..6 in register layout. In immediate layout `fld_c_o` reads as the no-register code and `shamt_o` as 0. `opcode_o` is bits 31..26.
- R3: For a legal immediate-layout word, `imm_o` is bits 15..0 sign-extended for opcodes 0x03 to 0x13, 0x25 and 0x26, and zero-extended for 0x0B, 0x0C and 0x22. For register layout it is 0.
- R4: A register-layout word whose opcode is neither 0x17 nor 0x18 and whose bits 10..6 are nonzero is illegal.
- R5: A register field that the opcode does not use must equal the no-register code (parameter `NOREG`, default 31), or the word is illegal.
- R6: A register field that the opcode reads or writes must not equal the no-register code, or the word is illegal.
- R7: Every opcode above 0x26 is illegal.
- R8: While `illegal_o` is high, `dec_valid_o`, `op_onehot_o`, `fmt_o`, `opcode_o`, all register fields, `shamt_o` and `imm_o` are all zero.
- R9: While `valid_i` is low, every output, including `illegal_o`, is zero.
- R10: For a legal word, `dec_valid_o` is 1 and `op_onehot_o` has exactly one bit set, at the index equal to the opcode.
- R11: The interrupt opcode 0x22 is illegal when immediate bits 15..8 are nonzero.
- R12: For the shift opcodes 0x17 and 0x18, field B (the shift-count register) may hold any code, including the no-register code, and the word stays legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Word on `instr_i` is to be decoded |
| dec_valid_o | output | 1 | Legal word decoded this cycle |
| illegal_o | output | 1 | Valid word is malformed |
| fmt_o | output | 2 | Layout: 0 register, 1 immediate |
| opcode_o | output | 6 | Opcode of the legal word |
| fld_a_o | output | 5 | Register field A (bits 25..21) |
| fld_b_o | output | 5 | Register field B (bits 20..16) |
| fld_c_o | output | 5 | Register field C (bits 15..11, register layout only) |
| shamt_o | output | 5 | Shift amount (register layout only) |
| imm_o | output | 32 | Extended immediate |
| op_onehot_o | output | 39 | One line per defined opcode |

## Verification
The two functions that meet in one evaluation are the field decode of a word and its rejection: a word can be well placed in every field yet carry a stray shift amount, a wrongly filled unused register slot, or an oversized interrupt code. The bench provokes this with words that are correct except for exactly one such flaw, next to the same word without the flaw. It judges that the flaw alone flips the result from a full decode to a raised illegal flag with every other output at zero. The shift opcodes are the deliberate counter-case: there a nonzero shift amount and a no-register count field must both pass.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  localparam int unsigned OPC_W   = 6;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned WORD_W  = 32;
  localparam logic [OPC_W-1:0] OP_LAST = 6'h26;
  localparam int unsigned NUM_OPS = int'(OP_LAST) + 1;

  localparam logic [OPC_W-1:0] OP_SHL  = 6'h17;
  localparam logic [OPC_W-1:0] OP_SHR  = 6'h18;
  localparam logic [OPC_W-1:0] OP_INT  = 6'h22;

  typedef enum logic [1:0] {
    FMT_REG = 2'd0,
    FMT_IMM = 2'd1,
    FMT_ABS = 2'd2
  } fmt_e;

  // how an operation treats one register field
  typedef enum logic [1:0] {
    FLD_EMPTY = 2'd0,  // must hold the no-register code
    FLD_REQ   = 2'd1,  // must name a real register
    FLD_ANY   = 2'd2   // not checked
  } fld_use_e;

  typedef struct packed {
    logic     known;
    logic     imm_fmt;
    fld_use_e use_a;
    fld_use_e use_b;
    fld_use_e use_c;
    logic     sext;
    logic     shift_op;
    logic     int_op;
  } op_info_t;

  function automatic op_info_t lookup_op(input logic [OPC_W-1:0] op);
    op_info_t r;
    r = '{known: 1'b0, imm_fmt: 1'b0, use_a: FLD_ANY, use_b: FLD_ANY,
          use_c: FLD_ANY, sext: 1'b0, shift_op: 1'b0, int_op: 1'b0};
    if (op <= OP_LAST) begin
      r.known = 1'b1;
      r.imm_fmt = ((op >= 6'h03) && (op <= 6'h13)) || (op == OP_INT) ||
                  (op == 6'h25) || (op == 6'h26);
      r.sext  = r.imm_fmt && (op != 6'h0B) && (op != 6'h0C) && (op != OP_INT);
      r.shift_op = (op == OP_SHL) || (op == OP_SHR);
      r.int_op   = (op == OP_INT);
      if (r.imm_fmt) begin
        r.use_c = FLD_ANY;
        if ((op == 6'h0B) || (op == 6'h0C)) begin
          r.use_a = FLD_EMPTY; r.use_b = FLD_REQ;
        end else if ((op >= 6'h0D) && (op <= 6'h13)) begin
          r.use_a = FLD_REQ;   r.use_b = FLD_EMPTY;
        end else if (op == OP_INT) begin
          r.use_a = FLD_EMPTY; r.use_b = FLD_EMPTY;
        end else begin
          r.use_a = FLD_REQ;   r.use_b = FLD_REQ;
        end
      end else begin
        if ((op == 6'h00) || (op == 6'h23) || (op == 6'h24)) begin
          r.use_a = FLD_EMPTY; r.use_b = FLD_EMPTY; r.use_c = FLD_EMPTY;
        end else if ((op == 6'h01) || (op == 6'h02) || (op == 6'h1D)) begin
          r.use_a = FLD_REQ;   r.use_b = FLD_EMPTY; r.use_c = FLD_REQ;
        end else if (op == 6'h14) begin
          r.use_a = FLD_REQ;   r.use_b = FLD_REQ;   r.use_c = FLD_EMPTY;
        end else if ((op == 6'h15) || (op == 6'h16)) begin
          r.use_a = FLD_EMPTY; r.use_b = FLD_EMPTY; r.use_c = FLD_REQ;
        end else if (r.shift_op) begin
          r.use_a = FLD_REQ;   r.use_b = FLD_ANY;   r.use_c = FLD_REQ;
        end else begin
          r.use_a = FLD_REQ;   r.use_b = FLD_REQ;   r.use_c = FLD_REQ;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/instr_field_split.sv
module instr_field_split
  import instr_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [OPC_W-1:0]  op_o,
  output logic [REG_W-1:0]  fa_o,
  output logic [REG_W-1:0]  fb_o,
  output logic [REG_W-1:0]  fc_o,
  output logic [REG_W-1:0]  sh_o,
  output logic [IMM_W-1:0]  imm_o
);
  always_comb begin
    op_o  = word_i[31:26];
    fa_o  = word_i[25:21];
    fb_o  = word_i[20:16];
    fc_o  = word_i[15:11];
    sh_o  = word_i[10:6];
    imm_o = word_i[15:0];
  end
endmodule

// File: rtl/instr_legality.sv
module instr_legality
  import instr_dec_pkg::*;
#(
  parameter logic [REG_W-1:0] NOREG = 5'h1F
) (
  input  op_info_t         info_i,
  input  logic [REG_W-1:0] fa_i,
  input  logic [REG_W-1:0] fb_i,
  input  logic [REG_W-1:0] fc_i,
  input  logic [REG_W-1:0] sh_i,
  input  logic [7:0]       int_hi_i,
  output logic             bad_o
);
  localparam int unsigned NFLD = 3;

  logic [REG_W-1:0] fld  [NFLD];
  fld_use_e         used [NFLD];
  logic [NFLD-1:0]  fld_bad;
  logic             sh_bad;
  logic             int_bad;

  always_comb begin
    fld[0]  = fa_i;          used[0] = info_i.use_a;
    fld[1]  = fb_i;          used[1] = info_i.use_b;
    fld[2]  = fc_i;          used[2] = info_i.use_c;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    always_comb begin
      unique case (used[g])
        FLD_EMPTY: fld_bad[g] = (fld[g] != NOREG);
        FLD_REQ:   fld_bad[g] = (fld[g] == NOREG);
        default:   fld_bad[g] = 1'b0;
      endcase
    end
  end

  always_comb begin
    sh_bad  = !info_i.imm_fmt && !info_i.shift_op && (sh_i != '0);
    int_bad = info_i.int_op && (int_hi_i != 8'h00);
    bad_o   = !info_i.known || sh_bad || int_bad || (|fld_bad);
  end
endmodule

// File: rtl/instr_onehot.sv
module instr_onehot
  import instr_dec_pkg::*;
#(
  parameter int unsigned N = NUM_OPS
) (
  input  logic [OPC_W-1:0] op_i,
  input  logic             en_i,
  output logic [N-1:0]     hot_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign hot_o[g] = en_i && (op_i == OPC_W'(g));
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter logic [4:0] NOREG = 5'h1F
) (
  input  logic [31:0] instr_i,
  input  logic        valid_i,
  output logic        dec_valid_o,
  output logic        illegal_o,
  output logic [1:0]  fmt_o,
  output logic [5:0]  opcode_o,
  output logic [4:0]  fld_a_o,
  output logic [4:0]  fld_b_o,
  output logic [4:0]  fld_c_o,
  output logic [4:0]  shamt_o,
  output logic [31:0] imm_o,
  output logic [38:0] op_onehot_o
);
  logic [OPC_W-1:0] op;
  logic [REG_W-1:0] fa, fb, fc, sh;
  logic [IMM_W-1:0] imm16;
  op_info_t         info;
  logic             bad;
  logic             take;

  instr_field_split u_split (
    .word_i (instr_i), .op_o (op), .fa_o (fa), .fb_o (fb),
    .fc_o (fc), .sh_o (sh), .imm_o (imm16)
  );

  always_comb info = lookup_op(op);

  instr_legality #(.NOREG (NOREG)) u_legal (
    .info_i (info), .fa_i (fa), .fb_i (fb), .fc_i (fc), .sh_i (sh),
    .int_hi_i (imm16[15:8]), .bad_o (bad)
  );

  always_comb begin
    take        = valid_i && !bad;
    dec_valid_o = take;
    illegal_o   = valid_i && bad;
    fmt_o       = take ? (info.imm_fmt ? FMT_IMM : FMT_REG) : 2'd0;
    opcode_o    = take ? op : '0;
    fld_a_o     = take ? fa : '0;
    fld_b_o     = take ? fb : '0;
    fld_c_o     = take ? (info.imm_fmt ? NOREG : fc) : '0;
    shamt_o     = (take && !info.imm_fmt) ? sh : '0;
    if (take && info.imm_fmt)
      imm_o = info.sext ? {{(WORD_W-IMM_W){imm16[IMM_W-1]}}, imm16}
                        : {{(WORD_W-IMM_W){1'b0}}, imm16};
    else
      imm_o = '0;
  end

  instr_onehot #(.N (NUM_OPS)) u_hot (
    .op_i (op), .en_i (take), .hot_o (op_onehot_o)
  );

  // checks against the raw word, next to the output logic
  logic raw_imm_layout;
  always_comb begin
    raw_imm_layout = ((instr_i[31:26] >= 6'h03) && (instr_i[31:26] <= 6'h13)) ||
                     (instr_i[31:26] == 6'h22) || (instr_i[31:26] == 6'h25) ||
                     (instr_i[31:26] == 6'h26);
    if (dec_valid_o)
      assert_onehot_R10: assert ($countones(op_onehot_o) == 1 && !illegal_o);
    if (illegal_o)
      assert_suppress_R8: assert (op_onehot_o == '0 && !dec_valid_o && imm_o == '0);
    if (!valid_i)
      assert_idle_R9: assert (!illegal_o && !dec_valid_o && $onehot0(op_onehot_o));
    if (valid_i && instr_i[31:26] > 6'h26)
      assert_range_R7: assert (illegal_o);
    if (valid_i && instr_i[31:26] <= 6'h26 && !raw_imm_layout &&
        instr_i[31:26] != 6'h17 && instr_i[31:26] != 6'h18 && instr_i[10:6] != 5'd0)
      assert_shamt_R4: assert (illegal_o);
  end
endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb_top;
  localparam logic [4:0] NR = 5'h1F;

  logic        clk;
  logic [31:0] instr;
  logic        valid;
  logic        dec_valid, illegal;
  logic [1:0]  fmt;
  logic [5:0]  opcode;
  logic [4:0]  fa, fb, fc, sh;
  logic [31:0] imm;
  logic [38:0] hot;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  instr_decoder dut_i (
    .instr_i (instr), .valid_i (valid), .dec_valid_o (dec_valid),
    .illegal_o (illegal), .fmt_o (fmt), .opcode_o (opcode),
    .fld_a_o (fa), .fld_b_o (fb), .fld_c_o (fc), .shamt_o (sh),
    .imm_o (imm), .op_onehot_o (hot)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk_r(logic [5:0] op, logic [4:0] a, logic [4:0] b,
                                       logic [4:0] c, logic [4:0] s);
    return {op, a, b, c, s, 6'b0};
  endfunction

  function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] a, logic [4:0] b,
                                       logic [15:0] v);
    return {op, a, b, v};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic v);
    @(negedge clk);
    instr = w;
    valid = v;
    #1;
  endtask

  task automatic expect_illegal(string tag);
    check({tag, " illegal"}, 64'(illegal), 64'd1);
    check({tag, " R8 dec_valid"}, 64'(dec_valid), 64'd0);
    check({tag, " R8 onehot"}, 64'(hot), 64'd0);
    check({tag, " R8 fields"}, 64'({fmt, opcode, fa, fb, fc, sh}), 64'd0);
    check({tag, " R8 imm"}, 64'(imm), 64'd0);
  endtask

  task automatic expect_legal(string tag, logic [5:0] op);
    check({tag, " illegal"}, 64'(illegal), 64'd0);
    check({tag, " R10 dec_valid"}, 64'(dec_valid), 64'd1);
    check({tag, " R10 onehot"}, 64'(hot), 64'(39'(1) << op));
    check({tag, " R2 opcode"}, 64'(opcode), 64'(op));
  endtask

  task automatic t_idle;
    apply(mk_r(6'h19, 5'd1, 5'd2, 5'd3, 5'd0), 1'b0);
    check("R9 idle flags", 64'({dec_valid, illegal}), 64'd0);
    check("R9 idle outputs", 64'({fmt, opcode, fa, fb, fc, sh}), 64'd0);
    check("R9 idle onehot/imm", 64'({hot, imm}), 64'd0);
    apply(32'hFFFF_FFFF, 1'b0);
    check("R9 idle bad word", 64'(illegal), 64'd0);
  endtask

  task automatic t_reg_ops;
    apply(mk_r(6'h19, 5'd1, 5'd2, 5'd3, 5'd0), 1'b1);
    expect_legal("R1 add", 6'h19);
    check("R1 add fmt", 64'(fmt), 64'd0);
    check("R2 add fields", 64'({fa, fb, fc, sh}), 64'({5'd1, 5'd2, 5'd3, 5'd0}));
    check("R3 add imm zero", 64'(imm), 64'd0);
    apply(mk_r(6'h1D, 5'd7, NR, 5'd9, 5'd0), 1'b1);
    expect_legal("R5 not", 6'h1D);
    apply(mk_r(6'h00, NR, NR, NR, 5'd0), 1'b1);
    expect_legal("R5 nop", 6'h00);
  endtask

  task automatic t_imm_ops;
    apply(mk_i(6'h07, 5'd4, 5'd5, 16'h8004), 1'b1);
    expect_legal("R1 ldw", 6'h07);
    check("R1 ldw fmt", 64'(fmt), 64'd1);
    check("R2 ldw fields", 64'({fa, fb, fc, sh}), 64'({5'd4, 5'd5, NR, 5'd0}));
    check("R3 ldw sext", 64'(imm), 64'h0000_0000_FFFF_8004);
    apply(mk_i(6'h0C, NR, 5'd6, 16'hABCD), 1'b1);
    expect_legal("R3 lui", 6'h0C);
    check("R3 lui zext", 64'(imm), 64'h0000_ABCD);
    apply(mk_i(6'h0B, NR, 5'd6, 16'h8000), 1'b1);
    check("R3 lli zext", 64'(imm), 64'h0000_8000);
    apply(mk_i(6'h0E, 5'd7, NR, 16'hFFFC), 1'b1);
    expect_legal("R3 jeq", 6'h0E);
    check("R3 jeq sext", 64'(imm), 64'h0000_0000_FFFF_FFFC);
    apply(mk_i(6'h26, 5'd2, 5'd2, 16'h0010), 1'b1);
    check("R1 isub fmt", 64'(fmt), 64'd1);
  endtask

  task automatic t_shift;
    apply(mk_r(6'h19, 5'd1, 5'd2, 5'd3, 5'd1), 1'b1);
    expect_illegal("R4 add shamt");
    apply(mk_r(6'h00, NR, NR, NR, 5'd3), 1'b1);
    expect_illegal("R4 nop shamt");
    apply(mk_r(6'h17, 5'd1, NR, 5'd1, 5'd5), 1'b1);
    expect_legal("R12 shl literal", 6'h17);
    check("R4 shl shamt", 64'(sh), 64'd5);
    apply(mk_r(6'h18, 5'd2, 5'd4, 5'd2, 5'd0), 1'b1);
    expect_legal("R12 shr reg", 6'h18);
    check("R12 shr fb", 64'(fb), 64'd4);
  endtask

  task automatic t_noreg;
    apply(mk_r(6'h14, 5'd1, 5'd2, 5'd3, 5'd0), 1'b1);
    expect_illegal("R5 cmp dest");
    apply(mk_r(6'h14, 5'd1, 5'd2, NR, 5'd0), 1'b1);
    expect_legal("R5 cmp ok", 6'h14);
    apply(mk_r(6'h00, 5'd0, NR, NR, 5'd0), 1'b1);
    expect_illegal("R5 nop field");
    apply(mk_i(6'h0B, 5'd3, 5'd6, 16'h0001), 1'b1);
    expect_illegal("R5 lli src");
    apply(mk_r(6'h19, NR, 5'd2, 5'd3, 5'd0), 1'b1);
    expect_illegal("R6 add src");
    apply(mk_i(6'h07, 5'd4, NR, 16'h0000), 1'b1);
    expect_illegal("R6 ldw dest");
  endtask

  task automatic t_range;
    apply(mk_r(6'h27, NR, NR, NR, 5'd0), 1'b1);
    expect_illegal("R7 op27");
    apply(32'hFFFF_FFFF, 1'b1);
    expect_illegal("R7 op3f");
  endtask

  task automatic t_int;
    apply(mk_i(6'h22, NR, NR, 16'h0021), 1'b1);
    expect_legal("R11 int ok", 6'h22);
    check("R11 int imm", 64'(imm), 64'h21);
    apply(mk_i(6'h22, NR, NR, 16'h0121), 1'b1);
    expect_illegal("R11 int wide");
  endtask

  initial begin
    instr = '0;
    valid = 1'b0;
    repeat (2) @(posedge clk);
    t_idle();
    t_reg_ops();
    t_imm_ops();
    t_shift();
    t_noreg();
    t_range();
    t_int();
    apply(mk_r(6'h19, 5'd1, 5'd2, 5'd3, 5'd0), 1'b0);
    check("R9 final idle", 64'({dec_valid, illegal}), 64'd0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule